// File: doc/BRIEF.md
# Multi-Channel Clock Gate Controller

This block drives eight downstream clock enables from one 32-bit control word, with four bits per channel. Software picks a mode for each channel. A channel can be held off, forced on, or gated automatically by its own activity request input. A read-only flag in each field shows whether the gated clock for that channel is still halted, so software can poll until a channel that it switched on is really running.

Writes come in on a fast bus clock. They are applied in a slower control clock domain. A write strobe crosses into that domain as a level toggle, so a write is not lost when the control clock is stopped; it takes effect once the clock runs again. The bus side paces writes by a fixed number of slow cycles, counted in bus cycles. A write-busy output covers that window. A write that arrives inside the window is dropped and raises a sticky overflow flag, which a read clears.

Top module: `clk_gate_ctrl`

## Requirements
- R1: Channel n owns bits [4n+3:4n] of the word. Bits [4n+1:4n] read back the mode last accepted for that channel, bit 4n+2 always reads 0 whatever was written, and bit 4n+3 is the stop flag.
- R2: The mode code sets the channel enable. 2'b00 holds it low, 2'b01 is reserved and also holds it low, 2'b10 holds it high, and 2'b11 selects automatic gating.
- R3: The stop flag of a channel reads 1 while that channel's enable is low. It reads 0 once the enable is high, seen through a two-stage bus-side synchroniser.
- R4: An accepted write raises wrBusy on the next bus edge. wrBusy stays high for exactly GAP_SLOW*CLK_RATIO bus cycles (40 by default).
- R5: A write while wrBusy is high is dropped, leaves the modes unchanged and sets wrOverflow. wrOverflow holds until a cycle with rdEn high and no new dropped write, then clears.
- R6: In automatic mode the enable rises on the first control-clock edge that samples actReq high. It falls on the second control-clock edge after actReq drops.
- R7: After reset all enables are low, every stop flag reads 1, all modes read 00, and wrBusy and wrOverflow are low.
- R8: The broadcast words 0x22222222, 0x33333333 and 0x00000000 set all eight channels to on, automatic and off.
- R9: A write accepted while the control clock is stopped takes effect after the clock restarts. A second identical write after the busy window leaves the channel state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| busClk | input | 1 | Fast bus clock |
| ctlClk | input | 1 | Slow control clock, may be stopped |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| wrEn | input | 1 | Write strobe for the control word |
| wrData | input | 32 | Write data |
| rdEn | input | 1 | Read strobe, clears the overflow flag |
| rdData | output | 32 | Control and status word |
| actReq | input | 8 | Per-channel activity request, control-clock domain |
| clkEn | output | 8 | Per-channel clock enable, control-clock domain |
| wrBusy | output | 1 | Write spacing window active |
| wrOverflow | output | 1 | Sticky flag for a dropped write |

## Verification
The checker watches the bus-side pacing on every cycle. An accepted write must raise busy, and a write during busy must set overflow and leave the readback modes alone. A read must clear overflow, and bit 2 of each field must stay zero. On every control-clock edge it also checks that a channel in on mode has its enable high and a channel in off or reserved mode has it low. The exact length of the busy window, the one- and two-edge timing of automatic gating, the settling of the stop flags, and the handling of a write made while the control clock is stopped are shown only by the bench's timed scenarios.

// File: rtl/cgc_pkg.sv
package cgc_pkg;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_RSVD = 2'b01,
    MODE_ON   = 2'b10,
    MODE_AUTO = 2'b11
  } gate_mode_e;

  // strobes from bus control to bus datapath
  typedef struct packed {
    logic accept;
    logic drop;
  } bus_strobe_t;

endpackage

// File: rtl/cgc_bus_ctrl.sv
module cgc_bus_ctrl
  import cgc_pkg::*;
#(
  parameter int GAP_CYCLES = 40
) (
  input  logic        busClk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        rdEn,
  output bus_strobe_t strobe,
  output logic        wrBusy,
  output logic        wrOverflow
);
  localparam int CW = $clog2(GAP_CYCLES + 1);

  logic [CW-1:0] gapCnt;
  logic          ovfQ;

  always_comb begin
    strobe.accept = wrEn && (gapCnt == '0);
    strobe.drop   = wrEn && (gapCnt != '0);
  end

  // spacing window counted in bus cycles
  always_ff @(posedge busClk or negedge rstN) begin
    if (!rstN) begin
      gapCnt <= '0;
    end else if (strobe.accept) begin
      gapCnt <= CW'(GAP_CYCLES);
    end else if (gapCnt != '0) begin
      gapCnt <= gapCnt - 1'b1;
    end
  end

  // sticky overflow, a new drop wins over a clearing read
  always_ff @(posedge busClk or negedge rstN) begin
    if (!rstN) begin
      ovfQ <= 1'b0;
    end else if (strobe.drop) begin
      ovfQ <= 1'b1;
    end else if (rdEn) begin
      ovfQ <= 1'b0;
    end
  end

  assign wrBusy     = (gapCnt != '0);
  assign wrOverflow = ovfQ;

endmodule

// File: rtl/cgc_bus_data.sv
module cgc_bus_data
  import cgc_pkg::*;
#(
  parameter int NCH = 8,
  localparam int WORD_W = 4 * NCH,
  localparam int MODE_W = 2 * NCH
) (
  input  logic              busClk,
  input  logic              rstN,
  input  bus_strobe_t       strobe,
  input  logic [WORD_W-1:0] wrData,
  input  logic [NCH-1:0]    enSlow,
  output logic [WORD_W-1:0] rdData,
  output logic [MODE_W-1:0] modeShadow,
  output logic              wrToggle
);
  logic [MODE_W-1:0] modeNext;
  logic [NCH-1:0]    enMeta;
  logic [NCH-1:0]    enSync;
  logic [NCH-1:0]    unusedHiBits;

  for (genvar g = 0; g < NCH; g++) begin : g_pick
    assign modeNext[2*g +: 2] = wrData[4*g +: 2];
    assign unusedHiBits[g]    = ^wrData[4*g+2 +: 2];
    assign rdData[4*g +: 4]   = {~enSync[g], 1'b0, modeShadow[2*g +: 2]};
  end

  // shadow stays stable for the whole spacing window, so the slow side
  // may sample it when it sees the toggle
  always_ff @(posedge busClk or negedge rstN) begin
    if (!rstN) begin
      modeShadow <= '0;
      wrToggle   <= 1'b0;
    end else if (strobe.accept) begin
      modeShadow <= modeNext;
      wrToggle   <= ~wrToggle;
    end
  end

  // enables from the control domain back into the bus domain
  always_ff @(posedge busClk or negedge rstN) begin
    if (!rstN) begin
      enMeta <= '0;
      enSync <= '0;
    end else begin
      enMeta <= enSlow;
      enSync <= enMeta;
    end
  end

endmodule

// File: rtl/cgc_chan.sv
module cgc_chan
  import cgc_pkg::*;
(
  input  logic       ctlClk,
  input  logic       rstN,
  input  gate_mode_e mode,
  input  logic       act,
  output logic       en
);
  logic reqQ;

  // auto: rise one edge after request, fall two edges after it drops
  always_ff @(posedge ctlClk or negedge rstN) begin
    if (!rstN) begin
      reqQ <= 1'b0;
      en   <= 1'b0;
    end else begin
      reqQ <= act;
      unique case (mode)
        MODE_ON:   en <= 1'b1;
        MODE_AUTO: en <= act | reqQ;
        default:   en <= 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/cgc_slow_gate.sv
module cgc_slow_gate
  import cgc_pkg::*;
#(
  parameter int NCH = 8,
  localparam int MODE_W = 2 * NCH
) (
  input  logic              ctlClk,
  input  logic              rstN,
  input  logic              wrToggle,
  input  logic [MODE_W-1:0] modeBus,
  input  logic [NCH-1:0]    actReq,
  output logic [NCH-1:0]    clkEn,
  output logic [MODE_W-1:0] slowMode
);
  logic togMeta, togSync, togLast;
  logic fire;

  always_ff @(posedge ctlClk or negedge rstN) begin
    if (!rstN) begin
      togMeta <= 1'b0;
      togSync <= 1'b0;
      togLast <= 1'b0;
    end else begin
      togMeta <= wrToggle;
      togSync <= togMeta;
      togLast <= togSync;
    end
  end

  assign fire = togSync ^ togLast;

  always_ff @(posedge ctlClk or negedge rstN) begin
    if (!rstN) begin
      slowMode <= '0;
    end else if (fire) begin
      slowMode <= modeBus;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    cgc_chan u_chan (
      .ctlClk (ctlClk),
      .rstN   (rstN),
      .mode   (gate_mode_e'(slowMode[2*g +: 2])),
      .act    (actReq[g]),
      .en     (clkEn[g])
    );
  end

endmodule

// File: rtl/clk_gate_ctrl.sv
module clk_gate_ctrl
  import cgc_pkg::*;
#(
  parameter int NCH       = 8,
  parameter int CLK_RATIO = 10,
  parameter int GAP_SLOW  = 4,
  localparam int WORD_W     = 4 * NCH,
  localparam int MODE_W     = 2 * NCH,
  localparam int GAP_CYCLES = CLK_RATIO * GAP_SLOW
) (
  input  logic              busClk,
  input  logic              ctlClk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [WORD_W-1:0] wrData,
  input  logic              rdEn,
  output logic [WORD_W-1:0] rdData,
  input  logic [NCH-1:0]    actReq,
  output logic [NCH-1:0]    clkEn,
  output logic              wrBusy,
  output logic              wrOverflow
);
  bus_strobe_t       strobe;
  logic [MODE_W-1:0] modeShadow;
  logic [MODE_W-1:0] slowMode;
  logic              wrToggle;

  cgc_bus_ctrl #(.GAP_CYCLES(GAP_CYCLES)) u_ctrl (
    .busClk     (busClk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .rdEn       (rdEn),
    .strobe     (strobe),
    .wrBusy     (wrBusy),
    .wrOverflow (wrOverflow)
  );

  cgc_bus_data #(.NCH(NCH)) u_data (
    .busClk     (busClk),
    .rstN       (rstN),
    .strobe     (strobe),
    .wrData     (wrData),
    .enSlow     (clkEn),
    .rdData     (rdData),
    .modeShadow (modeShadow),
    .wrToggle   (wrToggle)
  );

  cgc_slow_gate #(.NCH(NCH)) u_slow (
    .ctlClk   (ctlClk),
    .rstN     (rstN),
    .wrToggle (wrToggle),
    .modeBus  (modeShadow),
    .actReq   (actReq),
    .clkEn    (clkEn),
    .slowMode (slowMode)
  );

endmodule

// File: rtl/cgc_checker.sv
module cgc_checker #(
  parameter int NCH = 8,
  localparam int WORD_W = 4 * NCH,
  localparam int MODE_W = 2 * NCH
) (
  input logic              busClk,
  input logic              ctlClk,
  input logic              rstN,
  input logic              wrEn,
  input logic              rdEn,
  input logic [WORD_W-1:0] rdData,
  input logic [NCH-1:0]    clkEn,
  input logic              wrBusy,
  input logic              wrOverflow,
  input logic [MODE_W-1:0] slowMode
);
  localparam logic [WORD_W-1:0] MODE_MASK = {NCH{4'h3}};
  localparam logic [WORD_W-1:0] ZERO_MASK = {NCH{4'h4}};

  logic [NCH-1:0] onVec, offVec;
  for (genvar g = 0; g < NCH; g++) begin : g_vec
    assign onVec[g]  = (slowMode[2*g +: 2] == 2'b10);
    assign offVec[g] = !slowMode[2*g+1];
  end

  assert_busy_after_accept_R4: assert property (@(posedge busClk) disable iff (!rstN)
    (wrEn && !wrBusy) |=> wrBusy);

  assert_overflow_on_drop_R5: assert property (@(posedge busClk) disable iff (!rstN)
    (wrEn && wrBusy) |=> wrOverflow);

  assert_modes_kept_on_drop_R5: assert property (@(posedge busClk) disable iff (!rstN)
    (wrEn && wrBusy) |=> $stable(rdData & MODE_MASK));

  assert_read_clears_R5: assert property (@(posedge busClk) disable iff (!rstN)
    (rdEn && !(wrEn && wrBusy)) |=> !wrOverflow);

  assert_bit2_zero_R1: assert property (@(posedge busClk) disable iff (!rstN)
    (rdData & ZERO_MASK) == '0);

  assert_on_mode_high_R2: assert property (@(posedge ctlClk) disable iff (!rstN)
    ($past(onVec) & ~clkEn) == '0);

  assert_off_mode_low_R2: assert property (@(posedge ctlClk) disable iff (!rstN)
    ($past(offVec) & clkEn) == '0);

endmodule

bind clk_gate_ctrl cgc_checker #(.NCH(NCH)) u_chk (
  .busClk     (busClk),
  .ctlClk     (ctlClk),
  .rstN       (rstN),
  .wrEn       (wrEn),
  .rdEn       (rdEn),
  .rdData     (rdData),
  .clkEn      (clkEn),
  .wrBusy     (wrBusy),
  .wrOverflow (wrOverflow),
  .slowMode   (slowMode)
);

// File: tb/sim_clk_gate_ctrl.sv
module sim_clk_gate_ctrl;
  localparam int BUS_PERIOD = 10;
  localparam int CTL_HALF   = 50;
  localparam int SETTLE     = 70;
  localparam int GAP        = 40;

  logic        busClk = 1'b0;
  logic        ctlClk = 1'b0;
  logic        ctlRun = 1'b1;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic        rdEn = 1'b0;
  logic [31:0] rdData;
  logic [7:0]  actReq = '0;
  logic [7:0]  clkEn;
  logic        wrBusy, wrOverflow;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  // word, activity, expected enables
  localparam logic [47:0] VEC [6] = '{
    {32'h22222222, 8'h00, 8'hFF},
    {32'h00000000, 8'hFF, 8'h00},
    {32'h33333333, 8'hA5, 8'hA5},
    {32'h11111111, 8'hFF, 8'h00},
    {32'h32103210, 8'hFF, 8'hCC},
    {32'hFFFFFFFF, 8'h0F, 8'h0F}
  };

  clk_gate_ctrl u0 (
    .busClk(busClk), .ctlClk(ctlClk), .rstN(rstN),
    .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn), .rdData(rdData),
    .actReq(actReq), .clkEn(clkEn), .wrBusy(wrBusy), .wrOverflow(wrOverflow)
  );

  always #(BUS_PERIOD/2) busClk = ~busClk;

  initial begin
    forever begin
      #(CTL_HALF);
      if (ctlRun) ctlClk = ~ctlClk;
    end
  end

  function automatic logic [31:0] expWord(logic [31:0] w, logic [7:0] en);
    logic [31:0] r;
    for (int n = 0; n < 8; n++) begin
      r[4*n +: 2] = w[4*n +: 2];
      r[4*n+2]    = 1'b0;
      r[4*n+3]    = ~en[n];
    end
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic writeWord(logic [31:0] w);
    @(negedge busClk);
    wrEn = 1'b1; wrData = w;
    @(negedge busClk);
    wrEn = 1'b0;
  endtask

  task automatic waitBus(int n);
    for (int i = 0; i < n; i++) @(negedge busClk);
  endtask

  task automatic finish();
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(BUS_PERIOD * 150000);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=running expected=done");
      finish();
    end
  end

  initial begin
    int busyLen;
    waitBus(5);
    // R7 reset state
    chk("R7 rdData", rdData, 32'h88888888);
    chk("R7 clkEn", {24'h0, clkEn}, 32'h0);
    chk("R7 busy/ovf", {30'h0, wrBusy, wrOverflow}, 32'h0);
    @(negedge busClk) rstN = 1'b1;
    waitBus(5);

    // table walk: R1 R2 R3 R8
    for (int v = 0; v < 6; v++) begin
      actReq = VEC[v][15:8];
      writeWord(VEC[v][47:16]);
      waitBus(SETTLE);
      chk("R2/R8 clkEn", {24'h0, clkEn}, {24'h0, VEC[v][7:0]});
      chk("R1/R3 rdData", rdData, expWord(VEC[v][47:16], VEC[v][7:0]));
    end

    // R4 busy window length
    writeWord(32'h00000000);
    busyLen = 0;
    while (wrBusy && busyLen < 1000) begin
      busyLen++;
      @(negedge busClk);
    end
    chk("R4 busy cycles", busyLen, GAP);
    waitBus(SETTLE);

    // R5 dropped write and overflow
    writeWord(32'h22222222);
    writeWord(32'h33333333);
    chk("R5 overflow set", {31'h0, wrOverflow}, 32'h1);
    waitBus(SETTLE);
    chk("R5 modes kept", rdData, expWord(32'h22222222, 8'hFF));
    chk("R5 overflow sticky", {31'h0, wrOverflow}, 32'h1);
    @(negedge busClk) rdEn = 1'b1;
    @(negedge busClk) rdEn = 1'b0;
    chk("R5 overflow cleared", {31'h0, wrOverflow}, 32'h0);

    // R6 automatic gating timing
    actReq = 8'h00;
    writeWord(32'h33333333);
    waitBus(SETTLE);
    chk("R6 idle low", {24'h0, clkEn}, 32'h0);
    @(negedge ctlClk) actReq = 8'hFF;
    #1 chk("R6 not early", {24'h0, clkEn}, 32'h0);
    @(posedge ctlClk); #1;
    chk("R6 rise one edge", {24'h0, clkEn}, 32'hFF);
    @(negedge ctlClk) actReq = 8'h00;
    @(posedge ctlClk); #1;
    chk("R6 held first edge", {24'h0, clkEn}, 32'hFF);
    @(posedge ctlClk); #1;
    chk("R6 fall second edge", {24'h0, clkEn}, 32'h0);

    // R9 write while control clock is stopped
    writeWord(32'h00000000);
    waitBus(SETTLE);
    ctlRun = 1'b0;
    waitBus(20);
    writeWord(32'h22222222);
    waitBus(SETTLE);
    chk("R9 held while stopped", {24'h0, clkEn}, 32'h0);
    chk("R9 stop flags while stopped", rdData, 32'hAAAAAAAA);
    ctlRun = 1'b1;
    waitBus(SETTLE);
    chk("R9 applied after restart", {24'h0, clkEn}, 32'hFF);
    writeWord(32'h22222222);
    waitBus(SETTLE);
    chk("R9 repeat keeps state", rdData, expWord(32'h22222222, 8'hFF));
    chk("R9 repeat no overflow", {31'h0, wrOverflow}, 32'h0);

    finish();
  end

endmodule